// File: doc/BRIEF.md
# Processor Debug Unit with Trace Buffer

This block is a bus slave that gives any bus master debug control over a processor core. It sits on a 2 Mbyte address window, which it splits into three regions: control registers, a trace-memory window and a processor-state window. Through the control register a debugger can halt the core, resume it, and start or stop trace capture. Processor registers and caches are reached through a simple register-file style port, and only while the core reports that it has halted.

The trace buffer is a circular memory of 128-bit entries. Each entry records a transfer seen on a monitored system bus, or an executed instruction delivered on a trace input, or both kinds mixed. Every entry carries a timestamp from a free-running counter. The trace memory can be read only while capture is off. Capture turns off when software clears the enable bit, or by itself when the buffer fills in one-shot mode.

Any access that is not allowed in the current state completes without a wait state. It returns zero and writes nothing, so the bus never stalls.

Top module: `dbgTraceUnit`

## Requirements
- R1: Address decode uses two bits. Address bit 20 set selects the processor-state window. Bit 20 clear with bit 16 set selects the trace window. Both clear select the control registers. In the control space, address bits [3:2] pick the register: 0 control, 1 write index, 2 timestamp. Value 3 reads zero.
- R2: The control register can be read and written in any state. Its bits are: bit 0 halt request (read) / force halt (write); bit 1 resume (write only, reads 0); bit 2 trace enable; bit 3 bus-trace select; bit 4 instruction-trace select; bit 5 debug-mode status (read only); bit 6 one-shot stop.
- R3: Writing bit 0 as 1 raises `haltReq`, which stays high until a control write with bit 1 set. When both bits are written as 1 together, resume wins.
- R4: Control bit 5 reads back the core's halted acknowledge `haltAck`.
- R5: Processor-window accesses reach the core port only while `haltAck` is 1. A read returns `cpuRdata`, and a write pulses `cpuWe` with `cpuAddr` equal to address bits [19:2]. Otherwise a read returns zero and a write has no effect.
- R6: A read of the trace window returns zero while trace enable is 1.
- R7: The trace window address places the entry index in bits [11:4] and the word select in bits [3:2]. Word 0 is data, word 1 is address, word 2 bit 0 is the kind (1 instruction, 0 bus), and word 3 is the timestamp.
- R8: While trace enable is 1, a cycle with `monValid` and bus select stores a bus entry, and a cycle with `insValid` and instruction select stores an instruction entry. If both would be stored in the same cycle, only the instruction entry is kept.
- R9: The write index starts at 0, advances by one per stored entry, wraps from 255 to 0, and is readable.
- R10: With one-shot set, storing the entry at index 255 clears trace enable.
- R11: The timestamp counts up once per clock from reset. An entry holds the counter value of its capture cycle, and the timestamp register reads the current value.
- R12: After reset, the control register reads 0, the write index reads 0 and `haltReq` is 0.
- R13: Writes to the trace window are ignored. Read data appears in the cycle after the address phase, with no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select |
| haddr | input | 21 | Byte address within the 2 Mbyte window |
| htrans | input | 2 | Transfer type, bit 1 set for an active transfer |
| hwrite | input | 1 | Write when 1 |
| hreadyIn | input | 1 | Bus ready, address phase accepted when 1 |
| hwdata | input | 32 | Write data, valid in the data phase |
| hrdata | output | 32 | Read data, valid in the data phase |
| haltReq | output | 1 | Halt request to the core |
| haltAck | input | 1 | Core halted in debug mode |
| cpuAddr | output | 18 | Processor-state word address |
| cpuWdata | output | 32 | Processor-state write data |
| cpuWe | output | 1 | Processor-state write strobe |
| cpuRe | output | 1 | Processor-state read strobe |
| cpuRdata | input | 32 | Processor-state read data |
| monValid | input | 1 | Monitored bus transfer completes this cycle |
| monAddr | input | 32 | Monitored transfer address |
| monData | input | 32 | Monitored transfer data |
| insValid | input | 1 | Instruction executed this cycle |
| insPc | input | 32 | Instruction address |
| insWord | input | 32 | Instruction word |

## Verification
The assertions assume `haltAck` moves only in response to `haltReq`. They also assume that address and data phases follow the pipelined bus order, with one data phase after every accepted address phase. The bench keeps to both. Its core model registers `haltAck` from `haltReq` one cycle later. Every bus operation is issued alone as an address phase followed by an idle data phase. Trace stimulus is applied only in cycles with no bus operation in flight, so capture timing and register writes never overlap except where a test means them to.

// File: rtl/dbgPkg.sv
package dbgPkg;
  localparam int WORD_W = 32;
  localparam int WIN_W  = 21;

  typedef enum logic {
    KIND_BUS = 1'b0,
    KIND_INS = 1'b1
  } entryKindT;

  typedef struct packed {
    logic [WORD_W-1:0] stamp;
    logic [WORD_W-2:0] pad;
    entryKindT         kind;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } traceEntryT;

  typedef struct packed {
    logic capIns;
    logic capBus;
    logic selTrace;
    logic selIdx;
    logic selStamp;
  } dpStrobeT;
endpackage

// File: rtl/dbgCtrl.sv
module dbgCtrl
  import dbgPkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hsel,
  input  logic [WIN_W-1:0]    haddr,
  input  logic [1:0]          htrans,
  input  logic                hwrite,
  input  logic                hreadyIn,
  input  logic [WORD_W-1:0]   hwdata,
  input  logic                haltAck,
  input  logic                insValid,
  input  logic                monValid,
  input  logic                wrapNext,
  input  logic [WORD_W-1:0]   cpuRdata,
  output logic                haltReq,
  output logic [WIN_W-4:0]    cpuAddr,
  output logic [WORD_W-1:0]   cpuWdata,
  output logic                cpuWe,
  output logic                cpuRe,
  output logic [WORD_W-1:0]   ctrlRdata,
  output logic [IDX_W+1:0]    rdAddr,
  output dpStrobeT            stb
);
  localparam int CPU_BIT   = WIN_W - 1;
  localparam int TRACE_BIT = 16;
  localparam int B_HALT = 0, B_RESUME = 1, B_EN = 2, B_BUS = 3, B_INS = 4, B_DBG = 5, B_ONE = 6;

  logic                phValid, phWrite;
  logic [WIN_W-1:2]    phAddr;
  logic                traceEn, busSel, insSel, oneShot;
  logic                phCpu, phTrace, phReg, phRead, ctrlWr, cpuOk;
  logic [1:0]          regSel;
  logic                unusedBits;

  assign unusedBits = ^{htrans[0], haddr[1:0]};

  // address phase capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phValid <= 1'b0;
      phWrite <= 1'b0;
      phAddr  <= '0;
    end else begin
      phValid <= hsel && htrans[1] && hreadyIn;
      phWrite <= hwrite;
      phAddr  <= haddr[WIN_W-1:2];
    end
  end

  assign phCpu   = phAddr[CPU_BIT];
  assign phTrace = !phAddr[CPU_BIT] && phAddr[TRACE_BIT];
  assign phReg   = !phAddr[CPU_BIT] && !phAddr[TRACE_BIT];
  assign regSel  = phAddr[3:2];
  assign phRead  = phValid && !phWrite;
  assign ctrlWr  = phValid && phWrite && phReg && (regSel == 2'd0);

  // capture selection, instruction record wins a shared cycle
  always_comb begin
    stb.capIns   = traceEn && insSel && insValid;
    stb.capBus   = traceEn && busSel && monValid && !stb.capIns;
    stb.selTrace = phRead && phTrace && !traceEn;
    stb.selIdx   = phRead && phReg && (regSel == 2'd1);
    stb.selStamp = phRead && phReg && (regSel == 2'd2);
  end

  assign rdAddr = phAddr[IDX_W+3:2];

  // control register and halt handshake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltReq <= 1'b0;
      traceEn <= 1'b0;
      busSel  <= 1'b0;
      insSel  <= 1'b0;
      oneShot <= 1'b0;
    end else begin
      if (ctrlWr) begin
        if (hwdata[B_RESUME])    haltReq <= 1'b0;
        else if (hwdata[B_HALT]) haltReq <= 1'b1;
        traceEn <= hwdata[B_EN];
        busSel  <= hwdata[B_BUS];
        insSel  <= hwdata[B_INS];
        oneShot <= hwdata[B_ONE];
      end
      if ((stb.capIns || stb.capBus) && oneShot && wrapNext) traceEn <= 1'b0;
    end
  end

  // processor-state window gated by the halted acknowledge
  assign cpuOk    = phValid && phCpu && haltAck;
  assign cpuWe    = cpuOk && phWrite;
  assign cpuRe    = cpuOk && !phWrite;
  assign cpuAddr  = phAddr[WIN_W-2:2];
  assign cpuWdata = hwdata;

  always_comb begin
    ctrlRdata = '0;
    if (cpuRe) begin
      ctrlRdata = cpuRdata;
    end else if (phRead && phReg && (regSel == 2'd0)) begin
      ctrlRdata[B_HALT] = haltReq;
      ctrlRdata[B_EN]   = traceEn;
      ctrlRdata[B_BUS]  = busSel;
      ctrlRdata[B_INS]  = insSel;
      ctrlRdata[B_DBG]  = haltAck;
      ctrlRdata[B_ONE]  = oneShot;
    end
  end

  assert_halt_src_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltReq) |-> $past(ctrlWr && hwdata[B_HALT] && !hwdata[B_RESUME]));

  assert_resume_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && hwdata[B_RESUME]) |=> !haltReq);

  assert_cpu_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe || cpuRe) |-> haltAck);

  assert_one_kind_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.capIns, stb.capBus}));

  assert_oneshot_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.capIns || stb.capBus) && oneShot && wrapNext) |=> !traceEn);
endmodule

// File: rtl/dbgData.sv
module dbgData
  import dbgPkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          stb,
  input  logic [IDX_W+1:0]  rdAddr,
  input  logic [WORD_W-1:0] monAddr,
  input  logic [WORD_W-1:0] monData,
  input  logic [WORD_W-1:0] insPc,
  input  logic [WORD_W-1:0] insWord,
  output logic              wrapNext,
  output logic [WORD_W-1:0] dpRdata
);
  localparam int DEPTH = 1 << IDX_W;

  traceEntryT         mem [DEPTH];
  logic [IDX_W-1:0]   writeIdx;
  logic [WORD_W-1:0]  stamp;
  traceEntryT         newEntry, rdEntry;
  logic               capAny;

  assign capAny   = stb.capIns || stb.capBus;
  assign wrapNext = &writeIdx;

  always_comb begin
    newEntry       = '0;
    newEntry.stamp = stamp;
    newEntry.kind  = stb.capIns ? KIND_INS : KIND_BUS;
    newEntry.addr  = stb.capIns ? insPc : monAddr;
    newEntry.data  = stb.capIns ? insWord : monData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stamp    <= '0;
      writeIdx <= '0;
    end else begin
      stamp <= stamp + 1'b1;
      if (capAny) writeIdx <= writeIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (capAny) mem[writeIdx] <= newEntry;
  end

  assign rdEntry = mem[rdAddr[IDX_W+1:2]];

  always_comb begin
    dpRdata = '0;
    if (stb.selTrace) begin
      case (rdAddr[1:0])
        2'd0:    dpRdata = rdEntry.data;
        2'd1:    dpRdata = rdEntry.addr;
        2'd2:    dpRdata = {{(WORD_W-1){1'b0}}, rdEntry.kind};
        default: dpRdata = rdEntry.stamp;
      endcase
    end else if (stb.selIdx) begin
      dpRdata = {{(WORD_W-IDX_W){1'b0}}, writeIdx};
    end else if (stb.selStamp) begin
      dpRdata = stamp;
    end
  end

  assert_idx_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    capAny |=> writeIdx == $past(writeIdx) + 1'b1);

  assert_idx_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !capAny |=> $stable(writeIdx));

  assert_stamp_run_R11: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> stamp != $past(stamp));
endmodule

// File: rtl/dbgTraceUnit.sv
module dbgTraceUnit
  import dbgPkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsel,
  input  logic [WIN_W-1:0]  haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic              hreadyIn,
  input  logic [WORD_W-1:0] hwdata,
  output logic [WORD_W-1:0] hrdata,
  output logic              haltReq,
  input  logic              haltAck,
  output logic [WIN_W-4:0]  cpuAddr,
  output logic [WORD_W-1:0] cpuWdata,
  output logic              cpuWe,
  output logic              cpuRe,
  input  logic [WORD_W-1:0] cpuRdata,
  input  logic              monValid,
  input  logic [WORD_W-1:0] monAddr,
  input  logic [WORD_W-1:0] monData,
  input  logic              insValid,
  input  logic [WORD_W-1:0] insPc,
  input  logic [WORD_W-1:0] insWord
);
  dpStrobeT          stb;
  logic [IDX_W+1:0]  rdAddr;
  logic              wrapNext;
  logic [WORD_W-1:0] ctrlRdata, dpRdata;

  dbgCtrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hreadyIn(hreadyIn), .hwdata(hwdata), .haltAck(haltAck),
    .insValid(insValid), .monValid(monValid), .wrapNext(wrapNext),
    .cpuRdata(cpuRdata), .haltReq(haltReq), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuWe(cpuWe), .cpuRe(cpuRe),
    .ctrlRdata(ctrlRdata), .rdAddr(rdAddr), .stb(stb)
  );

  dbgData #(.IDX_W(IDX_W)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr),
    .monAddr(monAddr), .monData(monData), .insPc(insPc), .insWord(insWord),
    .wrapNext(wrapNext), .dpRdata(dpRdata)
  );

  assign hrdata = ctrlRdata | dpRdata;
endmodule

// File: tb/test_dbgTraceUnit.sv
module test_dbgTraceUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hsel = 1'b0, hwrite = 1'b0, hreadyIn = 1'b1;
  logic [20:0] haddr = '0;
  logic [1:0]  htrans = '0;
  logic [31:0] hwdata = '0, hrdata;
  logic        haltReq, haltAck, cpuWe, cpuRe;
  logic [17:0] cpuAddr;
  logic [31:0] cpuWdata, cpuRdata;
  logic        monValid = 1'b0, insValid = 1'b0;
  logic [31:0] monAddr = '0, monData = '0, insPc = '0, insWord = '0;

  int nChecks = 0, nErr = 0;
  bit done = 1'b0;
  logic [31:0] rd, ts0, ts1, ts2;
  logic [31:0] regFile [16];

  always #10 clk = ~clk;

  dbgTraceUnit i_dbgTraceUnit (
    .clk(clk), .rstN(rstN), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hreadyIn(hreadyIn), .hwdata(hwdata), .hrdata(hrdata),
    .haltReq(haltReq), .haltAck(haltAck), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuWe(cpuWe), .cpuRe(cpuRe), .cpuRdata(cpuRdata), .monValid(monValid),
    .monAddr(monAddr), .monData(monData), .insValid(insValid), .insPc(insPc),
    .insWord(insWord)
  );

  // core model: halts one cycle after request, small register file
  assign cpuRdata = regFile[cpuAddr[3:0]];
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltAck <= 1'b0;
      for (int i = 0; i < 16; i++) regFile[i] <= 32'hA500_0000 + i;
    end else begin
      haltAck <= haltReq;
      if (cpuWe) regFile[cpuAddr[3:0]] <= cpuWdata;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busOp(input bit wr, input logic [20:0] a, input logic [31:0] d,
                       output logic [31:0] r);
    @(negedge clk);
    hsel = 1'b1; htrans = 2'b10; hwrite = wr; haddr = a;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hwdata = d;
    #1 r = hrdata;
  endtask

  typedef struct packed {
    bit          wr;
    logic [20:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vecT;

  localparam int NV = 20;
  localparam vecT VECS [NV] = '{
    '{1'b0, 21'h000000, 32'h0, 32'h0000_0000, 4'd12},  // R12 control
    '{1'b0, 21'h000004, 32'h0, 32'h0000_0000, 4'd12},  // R12 index
    '{1'b0, 21'h100010, 32'h0, 32'h0000_0000, 4'd5},   // R5 not halted
    '{1'b1, 21'h000000, 32'h1, 32'h0,         4'd3},   // R3 force halt
    '{1'b0, 21'h000000, 32'h0, 32'h0000_0021, 4'd4},   // R4 halted status
    '{1'b0, 21'h100010, 32'h0, 32'hA500_0004, 4'd5},   // R5 read
    '{1'b1, 21'h100020, 32'h12345678, 32'h0,  4'd5},   // R5 write
    '{1'b0, 21'h100020, 32'h0, 32'h1234_5678, 4'd5},   // R5 readback
    '{1'b1, 21'h000000, 32'h2, 32'h0,         4'd3},   // R3 resume
    '{1'b0, 21'h000000, 32'h0, 32'h0000_0000, 4'd3},   // R3 released
    '{1'b1, 21'h100020, 32'hDEAD0000, 32'h0,  4'd5},   // R5 blocked write
    '{1'b1, 21'h000000, 32'h1, 32'h0,         4'd3},
    '{1'b0, 21'h100020, 32'h0, 32'h1234_5678, 4'd5},   // R5 unchanged
    '{1'b1, 21'h000000, 32'h3, 32'h0,         4'd3},   // R3 both bits, resume wins
    '{1'b0, 21'h000000, 32'h0, 32'h0000_0000, 4'd3},
    '{1'b0, 21'h00000C, 32'h0, 32'h0000_0000, 4'd1},   // R1 unused slot
    '{1'b1, 21'h000000, 32'h58, 32'h0,        4'd2},   // R2 layout
    '{1'b0, 21'h000000, 32'h0, 32'h0000_0058, 4'd2},
    '{1'b1, 21'h000000, 32'h0, 32'h0,         4'd2},
    '{1'b0, 21'h000000, 32'h0, 32'h0000_0000, 4'd2}
  };

  initial begin
    #(20 * 20000);
    if (!done) begin
      nErr++; nChecks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R12 haltReq", {31'b0, haltReq}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      busOp(VECS[v].wr, VECS[v].addr, VECS[v].data, rd);
      if (!VECS[v].wr) check($sformatf("R%0d vector %0d", VECS[v].req, v), rd, VECS[v].exp);
    end

    // trace enabled with both kinds: window locked (R6)
    busOp(1'b1, 21'h000000, 32'h1C, rd);
    busOp(1'b0, 21'h010000, 32'h0, rd);
    check("R6 locked read", rd, 32'h0);
    @(negedge clk); monValid = 1'b1; monAddr = 32'h1000; monData = 32'hBEEF;
    @(negedge clk); monValid = 1'b0; insValid = 1'b1; insPc = 32'h400; insWord = 32'h9100_0001;
    @(negedge clk); monValid = 1'b1; monAddr = 32'h2000; monData = 32'h5555; insPc = 32'h404; insWord = 32'h9200_0002;
    @(negedge clk); monValid = 1'b0; insValid = 1'b0;
    busOp(1'b1, 21'h000000, 32'h18, rd);
    busOp(1'b0, 21'h000004, 32'h0, rd);
    check("R9 index after three", rd, 32'd3);
    busOp(1'b0, 21'h010000, 32'h0, rd); check("R7 e0 data", rd, 32'hBEEF);
    busOp(1'b0, 21'h010004, 32'h0, rd); check("R7 e0 addr", rd, 32'h1000);
    busOp(1'b0, 21'h010008, 32'h0, rd); check("R7 e0 kind bus", rd, 32'h0);
    busOp(1'b0, 21'h010018, 32'h0, rd); check("R8 e1 kind ins", rd, 32'h1);
    busOp(1'b0, 21'h010014, 32'h0, rd); check("R8 e1 pc", rd, 32'h400);
    busOp(1'b0, 21'h010020, 32'h0, rd); check("R8 e2 ins priority", rd, 32'h9200_0002);
    busOp(1'b0, 21'h01000C, 32'h0, ts0);
    busOp(1'b0, 21'h01001C, 32'h0, ts1);
    busOp(1'b0, 21'h01002C, 32'h0, ts2);
    check("R11 stamp step e0-e1", ts1 - ts0, 32'd1);
    check("R11 stamp step e1-e2", ts2 - ts1, 32'd1);

    // R13: trace window write ignored
    busOp(1'b1, 21'h010000, 32'hFFFF_FFFF, rd);
    busOp(1'b0, 21'h010000, 32'h0, rd);
    check("R13 write ignored", rd, 32'hBEEF);

    // R11: timestamp register runs one per clock
    busOp(1'b0, 21'h000008, 32'h0, ts0);
    busOp(1'b0, 21'h000008, 32'h0, ts1);
    check("R11 stamp register", ts1 - ts0, 32'd2);

    // R8: bus-only select ignores instructions
    busOp(1'b1, 21'h000000, 32'h0C, rd);
    @(negedge clk); insValid = 1'b1;
    @(negedge clk); insValid = 1'b0; monValid = 1'b1; monData = 32'h7777;
    @(negedge clk); monValid = 1'b0;
    busOp(1'b1, 21'h000000, 32'h0, rd);
    busOp(1'b0, 21'h000004, 32'h0, rd);
    check("R8 bus-only index", rd, 32'd4);
    busOp(1'b0, 21'h010030, 32'h0, rd);
    check("R8 bus-only entry", rd, 32'h7777);

    // R10 and R9 wrap: one-shot stops after index 255
    busOp(1'b1, 21'h000000, 32'h4C, rd);
    for (int i = 0; i < 260; i++) begin
      @(negedge clk); monValid = 1'b1; monData = i;
    end
    @(negedge clk); monValid = 1'b0;
    busOp(1'b0, 21'h000000, 32'h0, rd);
    check("R10 enable cleared", rd, 32'h48);
    busOp(1'b0, 21'h000004, 32'h0, rd);
    check("R9 wrapped index", rd, 32'd0);
    busOp(1'b0, 21'h010FF0, 32'h0, rd);
    check("R9 last entry", rd, 32'd251);

    // R12: reset mid-run
    busOp(1'b1, 21'h000000, 32'h0D, rd);
    @(negedge clk); monValid = 1'b1;
    @(negedge clk); monValid = 1'b0; rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    check("R12 haltReq after reset", {31'b0, haltReq}, 32'h0);
    busOp(1'b0, 21'h000000, 32'h0, rd);
    check("R12 control after reset", rd, 32'h0);
    busOp(1'b0, 21'h000004, 32'h0, rd);
    check("R12 index after reset", rd, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule